// File: doc/BRIEF.md
# Time-Multiplexed Fetch Base Adder

This block forms address bits A9 to A13 for a video controller that interleaves two kinds of memory fetch: reads of the screen matrix and reads of character pattern data. A phase bit chooses which fetch is being addressed. The phase bit is the low bit of the horizontal cell counter and is supplied by the surrounding fetch sequencer. In the matrix phase, the 5-bit video base is added to bits 11:10 of the matrix counter. In the character phase, the 4-bit character base is added to bits 11:10 of the cell index, and cell-index bit 9 goes straight to A9.

Both sums run through one shared chain of five adder stages. Only one stage of the chain is a full adder. The phase bit steers the operands into the chain and the sums out of it. The two fetch types are offset from each other by one bit position, so the full adder produces A10 in the matrix phase and A11 in the character phase. The block is purely combinational. It drives the address bits active-low, ready for inverting pad drivers.

Top module: `fetch_base_adder`

## Requirements
- R1: With `phase_char_i` = 0 (matrix phase), the complement of `addr_n_o` equals ({`base_reg_i[7:4]`, `vbase9_i`} + `mtx_cnt_hi_i`) modulo 32.
- R2: With `phase_char_i` = 1 (character phase), the complement of `addr_n_o[4:1]` equals (`base_reg_i[3:0]` + `cell_idx_hi_i[2:1]`) modulo 16.
- R3: With `phase_char_i` = 1, `addr_n_o[0]` is the complement of `cell_idx_hi_i[0]` (cell-index bit 9), with no addition applied.
- R4: With `phase_char_i` = 1, `addr_n_o` does not depend on `base_reg_i[7:4]`, `vbase9_i` or `mtx_cnt_hi_i`.
- R5: With `phase_char_i` = 0, `addr_n_o` does not depend on `base_reg_i[3:0]` or `cell_idx_hi_i`.
- R6: Field layout: `base_reg_i[3:0]` holds character base bits 10..13 (LSB first), and `base_reg_i[7:4]` holds video base bits 10..13. Video base bit 9 arrives on `vbase9_i`. `mtx_cnt_hi_i[1:0]` carries counter bits 11:10, and `cell_idx_hi_i[2:0]` carries cell-index bits 11:9. Bit 0 of `addr_n_o` is A9 and bit 4 is A13.
- R7: The carry out of the top active stage is discarded. For example, a video base of 31 plus a count of 3 gives address 2, and a character base of 15 plus an index of 1 gives 0 in bits A13..A10.
- R8: Outputs are active-low. All-zero inputs in either phase give `addr_n_o` = 5'b11111.
- R9: With `phase_char_i` = 0, A9 (the lowest stage's sum) equals `vbase9_i` XOR `mtx_cnt_hi_i[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phase_char_i | input | 1 | Fetch phase: 0 = screen matrix, 1 = character data |
| base_reg_i | input | 8 | [3:0] character base bits 10..13, [7:4] video base bits 10..13 |
| vbase9_i | input | 1 | Video base bit 9 |
| mtx_cnt_hi_i | input | 2 | Matrix counter bits 11:10 |
| cell_idx_hi_i | input | 3 | Cell-index bits 11:9 |
| addr_n_o | output | 5 | Active-low A13..A9 (bit 0 = A9) |

## Verification
The assertions are immediate checks on the settled combinational result. They take for granted that every input holds a known 0 or 1 and that all inputs have stopped changing when the result is evaluated. The stimulus changes all inputs together, one vector per clock, and samples on the opposite edge, so only settled, fully known values are observed. The sweep covers every operand combination of both phases. Each combination is repeated with varying values on the fields that the active phase ignores.

// File: rtl/fba_pkg.sv
package fba_pkg;
    localparam int STAGES     = 5;
    localparam int FULL_STAGE = 1;
    localparam int VBASE_W    = STAGES;
    localparam int CBASE_W    = STAGES - 1;
    localparam int CNT_W      = 2;
    localparam int IDX_W      = CNT_W + 1;
    localparam int REG_W      = 2 * CBASE_W;

    typedef enum logic {
        PH_MATRIX = 1'b0,
        PH_CHAR   = 1'b1
    } fetch_phase_e;
endpackage

// File: rtl/fba_half.sv
module fba_half (
    input  logic x_i,
    input  logic y_i,
    output logic sum_o,
    output logic cout_o
);
    assign sum_o  = x_i ^ y_i;
    assign cout_o = x_i & y_i;
endmodule

// File: rtl/fba_full.sv
module fba_full (
    input  logic x_i,
    input  logic y_i,
    input  logic cin_i,
    output logic sum_o,
    output logic cout_o
);
    assign sum_o  = x_i ^ y_i ^ cin_i;
    assign cout_o = (x_i & y_i) | (cin_i & (x_i ^ y_i));
endmodule

// File: rtl/fba_sum_only.sv
module fba_sum_only (
    input  logic x_i,
    input  logic cin_i,
    output logic sum_o
);
    assign sum_o = x_i ^ cin_i;
endmodule

// File: rtl/fba_operand_steer.sv
module fba_operand_steer
    import fba_pkg::*;
(
    input  logic               phase_char_i,
    input  logic [REG_W-1:0]   base_reg_i,
    input  logic               vbase9_i,
    input  logic [CNT_W-1:0]   mtx_cnt_hi_i,
    input  logic [CNT_W-1:0]   cell_idx_up_i,
    output logic [STAGES-1:0]  opa_o,
    output logic [CNT_W-1:0]   opb_o
);
    fetch_phase_e phase;
    assign phase = fetch_phase_e'(phase_char_i);

    always_comb begin
        unique case (phase)
            PH_MATRIX: begin
                opa_o = {base_reg_i[REG_W-1:CBASE_W], vbase9_i};
                opb_o = mtx_cnt_hi_i;
            end
            PH_CHAR: begin
                opa_o = {1'b0, base_reg_i[CBASE_W-1:0]};
                opb_o = cell_idx_up_i;
            end
            default: begin
                opa_o = '0;
                opb_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/fba_result_steer.sv
module fba_result_steer
    import fba_pkg::*;
(
    input  logic              phase_char_i,
    input  logic [STAGES-1:0] sums_i,
    input  logic              idx9_i,
    output logic [STAGES-1:0] addr_n_o
);
    fetch_phase_e phase;
    assign phase = fetch_phase_e'(phase_char_i);

    always_comb begin
        unique case (phase)
            PH_MATRIX: addr_n_o = ~sums_i;
            PH_CHAR:   addr_n_o = ~{sums_i[STAGES-2:0], idx9_i};
            default:   addr_n_o = '1;
        endcase
    end
endmodule

// File: rtl/fetch_base_adder.sv
module fetch_base_adder
    import fba_pkg::*;
(
    input  logic                 phase_char_i,
    input  logic [REG_W-1:0]     base_reg_i,
    input  logic                 vbase9_i,
    input  logic [CNT_W-1:0]     mtx_cnt_hi_i,
    input  logic [IDX_W-1:0]     cell_idx_hi_i,
    output logic [STAGES-1:0]    addr_n_o
);
    logic [STAGES-1:0] opa;
    logic [CNT_W-1:0]  opb;
    logic [STAGES-1:0] sums;
    logic [STAGES-2:0] carry;

    fba_operand_steer u_ops (
        .phase_char_i  (phase_char_i),
        .base_reg_i    (base_reg_i),
        .vbase9_i      (vbase9_i),
        .mtx_cnt_hi_i  (mtx_cnt_hi_i),
        .cell_idx_up_i (cell_idx_hi_i[IDX_W-1:1]),
        .opa_o         (opa),
        .opb_o         (opb)
    );

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            fba_half u_add (
                .x_i(opa[k]), .y_i(opb[0]),
                .sum_o(sums[k]), .cout_o(carry[k])
            );
        end else if (k == FULL_STAGE) begin : g_full
            fba_full u_add (
                .x_i(opa[k]), .y_i(opb[1]), .cin_i(carry[k-1]),
                .sum_o(sums[k]), .cout_o(carry[k])
            );
        end else if (k == STAGES - 1) begin : g_last
            fba_sum_only u_add (
                .x_i(opa[k]), .cin_i(carry[k-1]), .sum_o(sums[k])
            );
        end else begin : g_mid
            fba_half u_add (
                .x_i(opa[k]), .y_i(carry[k-1]),
                .sum_o(sums[k]), .cout_o(carry[k])
            );
        end
    end

    fba_result_steer u_out (
        .phase_char_i (phase_char_i),
        .sums_i       (sums),
        .idx9_i       (cell_idx_hi_i[0]),
        .addr_n_o     (addr_n_o)
    );
endmodule

// File: rtl/fba_checker.sv
module fba_checker
    import fba_pkg::*;
(
    input logic                phase_char_i,
    input logic [REG_W-1:0]    base_reg_i,
    input logic                vbase9_i,
    input logic [CNT_W-1:0]    mtx_cnt_hi_i,
    input logic [IDX_W-1:0]    cell_idx_hi_i,
    input logic [STAGES-1:0]   addr_n_o
);
    logic [VBASE_W-1:0] vsum;
    logic [CBASE_W-1:0] csum;
    logic [STAGES-1:0]  addr;

    always_comb begin
        vsum = {base_reg_i[REG_W-1:CBASE_W], vbase9_i} + VBASE_W'(mtx_cnt_hi_i);
        csum = base_reg_i[CBASE_W-1:0] + CBASE_W'(cell_idx_hi_i[IDX_W-1:1]);
        addr = ~addr_n_o;
        if (!phase_char_i) begin
            assert_matrix_sum_R1: assert (addr == vsum);
            assert_matrix_a9_R9: assert (addr[0] == (vbase9_i ^ mtx_cnt_hi_i[0]));
        end else begin
            assert_char_sum_R2: assert (addr[STAGES-1:1] == csum);
            assert_char_a9_R3: assert (addr[0] == cell_idx_hi_i[0]);
        end
    end
endmodule

bind fetch_base_adder fba_checker u_fba_chk (
    .phase_char_i  (phase_char_i),
    .base_reg_i    (base_reg_i),
    .vbase9_i      (vbase9_i),
    .mtx_cnt_hi_i  (mtx_cnt_hi_i),
    .cell_idx_hi_i (cell_idx_hi_i),
    .addr_n_o      (addr_n_o)
);

// File: tb/fetch_base_adder_tb.sv
module fetch_base_adder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phase;
    logic [7:0] base;
    logic       vb9;
    logic [1:0] cnt;
    logic [2:0] idx;
    logic [4:0] addr_n;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    logic [7:0] lfsr = 8'hA5;

    always #10 clk = ~clk;

    fetch_base_adder u_dut (
        .phase_char_i  (phase),
        .base_reg_i    (base),
        .vbase9_i      (vb9),
        .mtx_cnt_hi_i  (cnt),
        .cell_idx_hi_i (idx),
        .addr_n_o      (addr_n)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            $display("FAIL watchdog: actual=%0d cycles expected<50000", cycles);
            errors = errors + 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    function automatic logic [4:0] expect_n(input logic p, input logic [7:0] b,
                                            input logic v9, input logic [1:0] c,
                                            input logic [2:0] ix);
        logic [4:0] s5;
        logic [3:0] s4;
        s5 = {b[7:4], v9} + {3'b000, c};
        s4 = b[3:0] + {2'b00, ix[2:1]};
        return p ? ~{s4, ix[0]} : ~s5;
    endfunction

    task automatic apply(input logic p, input logic [7:0] b, input logic v9,
                         input logic [1:0] c, input logic [2:0] ix, input string tag);
        logic [4:0] e;
        @(posedge clk);
        phase = p; base = b; vb9 = v9; cnt = c; idx = ix;
        e = expect_n(p, b, v9, c, ix);
        @(negedge clk);
        vectors++;
        if (addr_n !== e) begin
            errors++;
            $display("FAIL %s: p=%0b base=%h vb9=%0b cnt=%0d idx=%0d actual=%b expected=%b",
                     tag, p, b, v9, c, ix, addr_n, e);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    endtask

    initial begin
        phase = 1'b0; base = '0; vb9 = 1'b0; cnt = '0; idx = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R8: all-zero inputs, both phases, give all-ones outputs
        apply(1'b0, 8'h00, 1'b0, 2'd0, 3'd0, "R8 reset-state matrix");
        apply(1'b1, 8'h00, 1'b0, 2'd0, 3'd0, "R8 reset-state char");
        // R7: wrap cases
        apply(1'b0, 8'hF0, 1'b1, 2'd3, 3'd0, "R7 matrix wrap 31+3");
        apply(1'b1, 8'h0F, 1'b0, 2'd0, 3'd2, "R7 char wrap 15+1");
        // R1, R5, R6, R9: full matrix sweep, junk on ignored fields
        for (int j = 0; j < 4; j++) begin
            for (int v = 0; v < 32; v++) begin
                for (int c = 0; c < 4; c++) begin
                    step_lfsr();
                    apply(1'b0, {v[4:1], lfsr[3:0]}, v[0], c[1:0], lfsr[6:4],
                          "R1/R5/R6/R9 matrix sweep");
                end
            end
        end
        // R2, R3, R4, R6: full character sweep, junk on ignored fields
        for (int j = 0; j < 4; j++) begin
            for (int cb = 0; cb < 16; cb++) begin
                for (int ix = 0; ix < 8; ix++) begin
                    step_lfsr();
                    apply(1'b1, {lfsr[3:0], cb[3:0]}, lfsr[4], lfsr[6:5], ix[2:0],
                          "R2/R3/R4/R6 char sweep");
                end
            end
        end
        // R4 / R5: same active operands, opposite extremes on ignored fields
        apply(1'b1, 8'h05, 1'b0, 2'd0, 3'd5, "R4 char ignores video fields lo");
        apply(1'b1, 8'hF5, 1'b1, 2'd3, 3'd5, "R4 char ignores video fields hi");
        apply(1'b0, 8'h90, 1'b1, 2'd2, 3'd0, "R5 matrix ignores char fields lo");
        apply(1'b0, 8'h9F, 1'b1, 2'd2, 3'd7, "R5 matrix ignores char fields hi");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule